// File: doc/BRIEF.md
# Shadow-Backed Word SRAM with Bulk Store and Recall

This block is a small word-organized memory held in flip-flops. Every volatile word has a shadow word beside it that survives reset. Normal accesses are controlled by active-low chip-enable, output-enable and write-enable, an active-low hardware-store strobe, and two active-low byte-lane enables. Control is synchronous: inputs are sampled on the rising clock edge and read data appears, registered, one cycle later together with a drive-enable flag.

A bulk STORE copies all volatile words into their shadows in one step. A bulk RECALL copies all shadows back. STORE starts on a software pulse, on a falling edge of the hardware-store strobe, or on a rising edge of the power-fail input. RECALL starts on a software pulse or by itself in the first cycle after reset. A busy counter models the transfer time. While it runs, normal access is locked out. A saturating counter records how many STOREs have completed.

Top module: `nvs_sram_top`

## Requirements
- R1: A read is accepted when `ce_n`=0, `oe_n`=0, `we_n`=1 and `hsb_n`=1. One cycle later `rdata_oe`=1 and `rdata` holds the word as it was before that edge.
- R2: A write is accepted when `ce_n`=0, `we_n`=0 and `hsb_n`=1. If `oe_n` is low during a write, `rdata_oe` stays 0.
- R3: `bhe_n`=0 enables bits 15:8 and `ble_n`=0 enables bits 7:0. A disabled lane reads as zero and is not changed by a write. `rdata` is all zero whenever `rdata_oe`=0.
- R4: A STORE copies every volatile word into its shadow. A RECALL copies every shadow word back into volatile storage. Both act on all words in the same edge.
- R5: While `busy`=1, reads and writes are ignored and `rdata_oe` is 0 on the following cycle.
- R6: A STORE starts on a one-cycle `sw_store` pulse, on a high-to-low change of `hsb_n`, or on a low-to-high change of `pwr_fail`.
- R7: A RECALL starts on a `sw_recall` pulse, and also in the first clock cycle after reset is released.
- R8: `store_cnt` is 0 after reset. It rises by one when each STORE completes and saturates at `STORE_LIMIT` (default 1,000,000). STOREs still take place once it has saturated.
- R9: A transfer holds `busy` high for exactly `BUSY_CYC` cycles (default 16). The copy takes effect on the edge that ends the final busy cycle.
- R10: If STORE and RECALL triggers arrive in the same cycle, the STORE is performed. Any trigger that arrives while `busy`=1 is dropped.
- R11: A read or write presented in the same cycle that a transfer starts is discarded. This includes a write that coincides with a power-fail STORE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| hsb_n | input | 1 | Hardware-store strobe, active low |
| bhe_n | input | 1 | High byte lane enable, active low |
| ble_n | input | 1 | Low byte lane enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 2*BYTE_W | Write data |
| sw_store | input | 1 | Software STORE request pulse |
| sw_recall | input | 1 | Software RECALL request pulse |
| pwr_fail | input | 1 | Power-fail indication |
| rdata | output | 2*BYTE_W | Registered read data |
| rdata_oe | output | 1 | Read data drive enable |
| busy | output | 1 | Transfer in progress |
| store_cnt | output | CNT_W | Completed STORE count, saturating |

## Verification
A corrupted volatile word shows up as a wrong `rdata` on the next read of that address, one cycle after the read is presented. A corrupted shadow word stays hidden until a RECALL, either by software or at power-up, and then shows up on reads once `busy` falls. The bench therefore follows every transfer with reads against a model of both copies. A faulty busy counter or trigger arbiter shows up within the transfer window: `busy` stays high for the wrong number of cycles, `store_cnt` takes the wrong step, or data is copied in the wrong direction.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
   typedef enum logic [1:0] {
      XFER_IDLE   = 2'd0,
      XFER_STORE  = 2'd1,
      XFER_RECALL = 2'd2
   } xfer_kind_e;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/nvs_trig_arb.sv
module nvs_trig_arb (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic sw_store,
   input  logic sw_recall,
   input  logic hsb_n,
   input  logic pwr_fail,
   output logic start_store,
   output logic start_recall
);
   logic hsb_q;
   logic pf_q;
   logic por_pend;
   logic store_req;
   logic recall_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsb_q    <= 1'b1;
         pf_q     <= 1'b0;
         por_pend <= 1'b1;
      end else begin
         hsb_q    <= hsb_n;
         pf_q     <= pwr_fail;
         por_pend <= 1'b0;
      end
   end

   always_comb begin
      store_req    = sw_store | (hsb_q & ~hsb_n) | (~pf_q & pwr_fail);
      recall_req   = sw_recall | por_pend;
      start_store  = ~busy & store_req;
      start_recall = ~busy & ~store_req & recall_req;
   end
endmodule

// File: rtl/nvs_xfer_ctrl.sv
module nvs_xfer_ctrl
   import nvs_pkg::*;
#(
   parameter int unsigned BUSY_CYC    = 16,
   parameter int unsigned STORE_LIMIT = 1000000,
   parameter int unsigned CNT_W       = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_store,
   input  logic             start_recall,
   output logic             busy,
   output logic             do_store,
   output logic             do_recall,
   output logic [CNT_W-1:0] store_cnt
);
   localparam int unsigned TW = (BUSY_CYC < 2) ? 1 : $clog2(BUSY_CYC);
   localparam logic [TW-1:0]    LAST_TICK = TW'(BUSY_CYC - 1);
   localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(STORE_LIMIT);

   xfer_kind_e    kind_q;
   logic [TW-1:0] tick_q;
   logic          final_cyc;

   assign busy      = (kind_q != XFER_IDLE);
   assign final_cyc = busy && (tick_q == '0);
   assign do_store  = final_cyc && (kind_q == XFER_STORE);
   assign do_recall = final_cyc && (kind_q == XFER_RECALL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= XFER_IDLE;
         tick_q <= '0;
      end else if (!busy) begin
         if (start_store) begin
            kind_q <= XFER_STORE;
            tick_q <= LAST_TICK;
         end else if (start_recall) begin
            kind_q <= XFER_RECALL;
            tick_q <= LAST_TICK;
         end
      end else if (final_cyc) begin
         kind_q <= XFER_IDLE;
      end else begin
         tick_q <= tick_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         store_cnt <= '0;
      else if (do_store && (store_cnt != CNT_MAX))
         store_cnt <= store_cnt + 1'b1;
   end
endmodule

// File: rtl/nvs_word_cell.sv
module nvs_word_cell #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned LANES  = 2
) (
   input  logic                    clk,
   input  logic                    wr_sel,
   input  logic [LANES-1:0]        lane_en,
   input  logic [LANES*BYTE_W-1:0] wdata,
   input  logic                    do_store,
   input  logic                    do_recall,
   output logic [LANES*BYTE_W-1:0] vol_word
);
   logic [LANES*BYTE_W-1:0] shadow_q;

   always_ff @(posedge clk) begin
      if (do_store) shadow_q <= vol_word;
   end

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      always_ff @(posedge clk) begin
         if (do_recall)
            vol_word[ln*BYTE_W +: BYTE_W] <= shadow_q[ln*BYTE_W +: BYTE_W];
         else if (wr_sel && lane_en[ln])
            vol_word[ln*BYTE_W +: BYTE_W] <= wdata[ln*BYTE_W +: BYTE_W];
      end
   end
endmodule

// File: rtl/nvs_sram_top.sv
module nvs_sram_top
   import nvs_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned BUSY_CYC    = 16,
   parameter int unsigned STORE_LIMIT = 1000000,
   parameter int unsigned CNT_W       = cnt_width(STORE_LIMIT)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ce_n,
   input  logic                oe_n,
   input  logic                we_n,
   input  logic                hsb_n,
   input  logic                bhe_n,
   input  logic                ble_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [2*BYTE_W-1:0] wdata,
   input  logic                sw_store,
   input  logic                sw_recall,
   input  logic                pwr_fail,
   output logic [2*BYTE_W-1:0] rdata,
   output logic                rdata_oe,
   output logic                busy,
   output logic [CNT_W-1:0]    store_cnt
);
   localparam int unsigned DEPTH  = 1 << ADDR_W;
   localparam int unsigned LANES  = 2;
   localparam int unsigned WORD_W = LANES * BYTE_W;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("nvs_sram_top: ADDR_W out of range");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("nvs_sram_top: BYTE_W must be positive");
   end
   if (BUSY_CYC < 1) begin : g_bad_busy
      $error("nvs_sram_top: BUSY_CYC must be at least 1");
   end
   if (STORE_LIMIT < 1 || CNT_W < cnt_width(STORE_LIMIT)) begin : g_bad_cnt
      $error("nvs_sram_top: counter too narrow for STORE_LIMIT");
   end

   logic              start_store;
   logic              start_recall;
   logic              do_store;
   logic              do_recall;
   logic              acc_ok;
   logic              wr_go;
   logic              rd_go;
   logic [LANES-1:0]  lane_en;
   logic [WORD_W-1:0] lane_mask;
   logic [WORD_W-1:0] vol_words [DEPTH];

   nvs_trig_arb u_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .busy         (busy),
      .sw_store     (sw_store),
      .sw_recall    (sw_recall),
      .hsb_n        (hsb_n),
      .pwr_fail     (pwr_fail),
      .start_store  (start_store),
      .start_recall (start_recall)
   );

   nvs_xfer_ctrl #(
      .BUSY_CYC    (BUSY_CYC),
      .STORE_LIMIT (STORE_LIMIT),
      .CNT_W       (CNT_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_store  (start_store),
      .start_recall (start_recall),
      .busy         (busy),
      .do_store     (do_store),
      .do_recall    (do_recall),
      .store_cnt    (store_cnt)
   );

   always_comb begin
      acc_ok     = ~busy & ~start_store & ~start_recall & ~ce_n & hsb_n;
      wr_go      = acc_ok & ~we_n;
      rd_go      = acc_ok & ~oe_n & we_n;
      lane_en[0] = ~ble_n;
      lane_en[1] = ~bhe_n;
   end

   for (genvar ln = 0; ln < LANES; ln++) begin : g_mask
      assign lane_mask[ln*BYTE_W +: BYTE_W] = {BYTE_W{lane_en[ln]}};
   end

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      nvs_word_cell #(
         .BYTE_W (BYTE_W),
         .LANES  (LANES)
      ) u_cell (
         .clk       (clk),
         .wr_sel    (wr_go && (addr == ADDR_W'(w))),
         .lane_en   (lane_en),
         .wdata     (wdata),
         .do_store  (do_store),
         .do_recall (do_recall),
         .vol_word  (vol_words[w])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata    <= '0;
         rdata_oe <= 1'b0;
      end else if (rd_go) begin
         rdata    <= vol_words[addr] & lane_mask;
         rdata_oe <= 1'b1;
      end else begin
         rdata    <= '0;
         rdata_oe <= 1'b0;
      end
   end
endmodule

// File: rtl/nvs_sram_chk.sv
module nvs_sram_chk #(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned BUSY_CYC    = 16,
   parameter int unsigned STORE_LIMIT = 1000000,
   parameter int unsigned CNT_W       = 20
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ce_n,
   input logic                we_n,
   input logic                bhe_n,
   input logic                ble_n,
   input logic [2*BYTE_W-1:0] rdata,
   input logic                rdata_oe,
   input logic                busy,
   input logic [CNT_W-1:0]    store_cnt
);
   logic [31:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_q <= '0;
      else if (busy) run_q <= run_q + 1;
      else           run_q <= '0;
   end

   a_r5_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !rdata_oe);
   a_r2_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !we_n) |=> !rdata_oe);
   a_r3_hi_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bhe_n |=> (rdata[2*BYTE_W-1:BYTE_W] == '0));
   a_r3_lo_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ble_n |=> (rdata[BYTE_W-1:0] == '0));
   a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_oe |-> (rdata == '0));
   a_r9_busy_max: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= BUSY_CYC);
   a_r9_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_q == BUSY_CYC));
   a_r8_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
      store_cnt <= CNT_W'(STORE_LIMIT));
   a_r8_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(store_cnt) |-> ($fell(busy) && store_cnt == $past(store_cnt) + 1'b1));
endmodule

bind nvs_sram_top nvs_sram_chk #(
   .BYTE_W      (BYTE_W),
   .BUSY_CYC    (BUSY_CYC),
   .STORE_LIMIT (STORE_LIMIT),
   .CNT_W       (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ce_n      (ce_n),
   .we_n      (we_n),
   .bhe_n     (bhe_n),
   .ble_n     (ble_n),
   .rdata     (rdata),
   .rdata_oe  (rdata_oe),
   .busy      (busy),
   .store_cnt (store_cnt)
);

// File: tb/tb_nvs_sram_top.sv
module tb_nvs_sram_top;
   localparam int BUSY  = 16;
   localparam int LIMIT = 5;
   localparam int CW    = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n, oe_n, we_n, hsb_n, bhe_n, ble_n;
   logic [7:0]  addr;
   logic [15:0] wdata;
   logic sw_store, sw_recall, pwr_fail;
   logic [15:0] rdata;
   logic rdata_oe, busy;
   logic [CW-1:0] store_cnt;

   int total = 0;
   int bad = 0;
   int nstores = 0;
   bit done = 0;
   logic [15:0] vol_m [256];
   logic [15:0] sh_m  [256];

   always #10 clk = ~clk;

   nvs_sram_top #(.ADDR_W(8), .BYTE_W(8), .BUSY_CYC(BUSY), .STORE_LIMIT(LIMIT), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .hsb_n(hsb_n),
      .bhe_n(bhe_n), .ble_n(ble_n), .addr(addr), .wdata(wdata), .sw_store(sw_store),
      .sw_recall(sw_recall), .pwr_fail(pwr_fail), .rdata(rdata), .rdata_oe(rdata_oe),
      .busy(busy), .store_cnt(store_cnt));

   function automatic logic [15:0] lane_view(logic [15:0] w, logic bh, logic bl);
      return {(bh ? 8'h00 : w[15:8]), (bl ? 8'h00 : w[7:0])};
   endfunction
   function automatic logic [15:0] merge(logic [15:0] old, logic [15:0] d, logic bh, logic bl);
      return {(bh ? old[15:8] : d[15:8]), (bl ? old[7:0] : d[7:0])};
   endfunction
   function automatic int exp_cnt(int n);
      return (n > LIMIT) ? LIMIT : n;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      ce_n = 1; oe_n = 1; we_n = 1; hsb_n = 1; bhe_n = 0; ble_n = 0;
      addr = '0; wdata = '0; sw_store = 0; sw_recall = 0; pwr_fail = 0;
   endtask

   task automatic do_write(logic [7:0] a, logic [15:0] d, logic bh, logic bl, logic oe);
      ce_n = 0; we_n = 0; oe_n = oe; addr = a; wdata = d; bhe_n = bh; ble_n = bl;
      tick();
      vol_m[a] = merge(vol_m[a], d, bh, bl);
      if (!oe) check("R2 oe low during write", {31'd0, rdata_oe}, 32'd0);
      idle();
   endtask

   task automatic do_read(logic [7:0] a, logic bh, logic bl, string req);
      ce_n = 0; oe_n = 0; we_n = 1; addr = a; bhe_n = bh; ble_n = bl;
      tick();
      check({req, " oe"}, {31'd0, rdata_oe}, 32'd1);
      check({req, " data"}, {16'd0, rdata}, {16'd0, lane_view(vol_m[a], bh, bl)});
      idle();
   endtask

   // mode 0: idle, 1: write/read attempts, 2: recall pulse attempts
   task automatic wait_xfer(bit is_store, int mode, string req);
      int n = 0;
      check({req, " busy start"}, {31'd0, busy}, 32'd1);
      while (busy && n < 64) begin
         n++;
         idle();
         if (mode == 1) begin
            ce_n = 0; addr = 8'd7; wdata = 16'hDEAD;
            if (n[0]) we_n = 0; else oe_n = 0;
         end else if (mode == 2) begin
            sw_recall = 1;
         end
         tick();
         if (mode == 1) check("R5 no output while busy", {31'd0, rdata_oe}, 32'd0);
      end
      idle();
      check("R9 busy length", n, BUSY);
      if (is_store) begin
         for (int i = 0; i < 256; i++) sh_m[i] = vol_m[i];
         nstores++;
      end else begin
         for (int i = 0; i < 256; i++) vol_m[i] = sh_m[i];
      end
      check("R8 store count", {29'd0, store_cnt}, exp_cnt(nstores));
   endtask

   task automatic power_cycle();
      rst_n = 0;
      tick(); tick();
      check("R8 count reset", {29'd0, store_cnt}, 32'd0);
      check("R5 busy reset", {31'd0, busy}, 32'd0);
      check("R1 oe reset", {31'd0, rdata_oe}, 32'd0);
      nstores = 0;
      rst_n = 1;
      tick();
      wait_xfer(0, 0, "R7 power-up recall");
   endtask

   initial begin
      void'($urandom(32'd4242));
      idle();
      tick();
      power_cycle();
      for (int i = 0; i < 256; i++) do_write(8'(i), 16'($urandom), 0, 0, 1);
      sw_store = 1; tick(); sw_store = 0;
      wait_xfer(1, 0, "R6 sw store");
      do_read(8'd3, 0, 0, "R1 read");

      // R3 lanes
      do_write(8'd10, 16'hA5C3, 0, 0, 1);
      do_write(8'd10, 16'h1177, 1, 0, 1);
      do_read(8'd10, 0, 0, "R3 low lane write");
      do_write(8'd10, 16'h9900, 0, 1, 1);
      do_read(8'd10, 1, 0, "R3 high lane disabled");
      do_read(8'd10, 0, 1, "R3 low lane disabled");
      do_write(8'd11, 16'h5A5A, 0, 0, 0);
      do_read(8'd11, 0, 0, "R2 write with oe low");

      // R5 access ignored while busy
      sw_store = 1; tick(); sw_store = 0;
      wait_xfer(1, 1, "R5 store with access");
      do_read(8'd7, 0, 0, "R5 write ignored");

      // R10 store wins, busy trigger dropped
      do_write(8'd20, 16'h0F0F, 0, 0, 1);
      sw_store = 1; sw_recall = 1; tick(); idle();
      wait_xfer(1, 2, "R10 store wins");
      tick();
      check("R10 busy trigger dropped", {31'd0, busy}, 32'd0);
      do_read(8'd20, 0, 0, "R10 data after");

      // R4 recall restores
      do_write(8'd20, 16'hBEEF, 0, 0, 1);
      do_write(8'd200, 16'h1234, 0, 0, 1);
      sw_recall = 1; tick(); idle();
      wait_xfer(0, 0, "R7 sw recall");
      do_read(8'd20, 0, 0, "R4 recall word 20");
      do_read(8'd200, 0, 0, "R4 recall word 200");

      // R6 hsb falling edge, R11 power-fail write discarded
      do_write(8'd30, 16'h3030, 0, 0, 1);
      hsb_n = 0; tick();
      begin
         int n = 0;
         check("R6 hsb store start", {31'd0, busy}, 32'd1);
         while (busy && n < 64) begin n++; tick(); end
         check("R9 hsb busy length", n, BUSY);
         for (int i = 0; i < 256; i++) sh_m[i] = vol_m[i];
         nstores++;
      end
      ce_n = 0; oe_n = 0; addr = 8'd30; tick();
      check("R1 no read with hsb low", {31'd0, rdata_oe}, 32'd0);
      idle(); tick();
      check("R6 hsb rise no trigger", {31'd0, busy}, 32'd0);
      pwr_fail = 1; ce_n = 0; we_n = 0; addr = 8'd30; wdata = 16'hFFFF; tick();
      pwr_fail = 1; ce_n = 1; we_n = 1;
      begin
         int n = 0;
         check("R6 power-fail store", {31'd0, busy}, 32'd1);
         while (busy && n < 64) begin n++; tick(); end
         check("R9 pf busy length", n, BUSY);
         for (int i = 0; i < 256; i++) sh_m[i] = vol_m[i];
         nstores++;
         check("R8 count after pf", {29'd0, store_cnt}, exp_cnt(nstores));
      end
      idle();
      do_read(8'd30, 0, 0, "R11 write discarded");

      // R7 power-up recall restores shadow
      do_write(8'd40, 16'h4444, 0, 0, 1);
      power_cycle();
      do_read(8'd40, 0, 0, "R7 reset recall data");

      // random mix
      for (int it = 0; it < 500; it++) begin
         int r = int'($urandom % 12);
         logic [7:0] a = 8'($urandom);
         if (r < 6) do_write(a, 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
         else if (r < 10) do_read(a, 1'($urandom), 1'($urandom), "R1 random read");
         else if (r == 10) begin sw_store = 1; tick(); idle(); wait_xfer(1, 0, "R8 random store"); end
         else begin sw_recall = 1; tick(); idle(); wait_xfer(0, 0, "R4 random recall"); end
      end
      for (int k = 0; k < LIMIT + 2; k++) begin
         sw_store = 1; tick(); idle(); wait_xfer(1, 0, "R8 saturation");
      end
      check("R8 saturated", {29'd0, store_cnt}, LIMIT);
      done = 1;
   end

   initial begin
      fork
         wait (done == 1);
         begin
            repeat (150000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule